// File: doc/BRIEF.md
# Synchronous Serial Master Transmitter with Clock Output

This block is the transmit side of a serial port that runs as a synchronous master. A byte taken on a write strobe is sent on `tx_o` least significant bit first. Each frame has one low start bit, the data bits and one high stop bit. Every bit lasts two baud ticks, and the ticks come from an external divider. The block always drives the serial clock `ck_o` itself. It never accepts a clock from outside. Clock pulses appear only during the data bits, so a receiver can capture them.

The block also produces a one-cycle sample strobe for the receive input. The strobe falls at the middle of each data bit, which is the capture edge in both phase settings, and the strobe fills a receive byte. The clock polarity, the clock phase and the option that suppresses the clock of the final data bit are loaded only while both directions are disabled. A break request sends a frame whose start and data bits are low, with no clock and no sampling.

Top module: `uart_sync_master`

## Requirements
- R1: After reset, `tx_o` is 1, `ck_o` is 0, and `busy_o`, `rx_sample_o` and `rx_valid_o` are 0.
- R2: A write accepted while idle and enabled raises `busy_o` on the next cycle. `tx_o` then shows start (0), data bits LSB first, and stop (1), each for two baud ticks. `busy_o` falls at the tick that ends the stop bit.
- R3: Outside data bits (idle, start, stop, break) `ck_o` equals the latched polarity: 0 gives a low idle level and 1 gives a high idle level.
- R4: With phase 0, `ck_o` leaves its idle level at the mid-bit tick of a data bit and returns at the bit-end tick. With phase 1, it leaves at bit start and returns at the mid-bit tick.
- R5: With the last-bit option at 1, all DATA_W data bits get a clock pulse (2*DATA_W edges per frame). With the option at 0, the MSB bit gets none (2*(DATA_W-1) edges).
- R6: While the receiver is enabled, `rx_sample_o` pulses for one cycle on the mid-bit tick of every data bit, including the MSB. It never pulses while the receiver is disabled or during a break.
- R7: Sampled `rx_i` bits fill `rx_data_o` LSB first. `rx_valid_o` pulses for one cycle in the cycle after the MSB sample.
- R8: Polarity, phase and last-bit settings are latched only in cycles where `tx_en_i` and `rx_en_i` are both 0. Changes at other times have no effect on `ck_o`.
- R9: A write while `busy_o` is 1, or while `tx_en_i` is 0, is ignored and starts no frame.
- R10: `brk_i` while idle sends a frame with low start and data bits and a high stop bit, with no CK edges and no sample strobes. When `wr_i` and `brk_i` come together, the write wins.
- R11: When `tx_en_i` is 0, any frame is aborted, so `busy_o` is 0 and `tx_o` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| cfg_pol_i | input | 1 | Clock idle level |
| cfg_pha_i | input | 1 | Clock phase: 0 capture on first edge, 1 on second |
| cfg_lbclk_i | input | 1 | Emit clock pulse for the MSB data bit |
| baud_tick_i | input | 1 | Half-bit tick from the baud divider |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Byte to send |
| brk_i | input | 1 | Break request |
| rx_i | input | 1 | Serial receive input |
| tx_o | output | 1 | Serial transmit output |
| ck_o | output | 1 | Serial clock output |
| busy_o | output | 1 | Frame in progress |
| rx_sample_o | output | 1 | Receive sample strobe |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | Received byte update pulse |

## Verification
The hardest situations to reach from the ports are the ones that depend on when a request arrives within a frame. These are a configuration change while enabled, a write while a frame is in flight, and an abort in the middle of a data bit. The bench runs a cycle-level reference model of the frame and issues those requests at fixed offsets after a frame starts. It also uses tick rates of one, three and four clocks, so tick and request timing line up in more than one way. Counts of clock edges and sample strobes per frame are taken at the ports to cover the last-bit option and break frames.

// File: rtl/uart_sync_pkg.sv
package uart_sync_pkg;
  typedef struct packed {
    logic pol;
    logic pha;
    logic lbclk;
  } ck_cfg_t;
endpackage

// File: rtl/uart_sync_cfg.sv
module uart_sync_cfg
  import uart_sync_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tx_en_i,
  input  logic    rx_en_i,
  input  logic    pol_i,
  input  logic    pha_i,
  input  logic    lbclk_i,
  output ck_cfg_t cfg_o
);
  ck_cfg_t cfg_q;
  logic    load;

  assign load = !tx_en_i && !rx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q.pol   <= pol_i;
      cfg_q.pha   <= pha_i;
      cfg_q.lbclk <= lbclk_i;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/uart_sync_seq.sv
module uart_sync_seq #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              brk_i,
  output logic              busy_o,
  output logic              tx_o,
  output logic              data_bit_o,
  output logic              last_bit_o,
  output logic              half_o,
  output logic              mid_tick_o,
  output logic [IDX_W-1:0]  data_idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(DATA_W);

  logic              busy_q, brk_q, half_q;
  logic [IDX_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              in_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      brk_q  <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else if (!tx_en_i) begin
      busy_q <= 1'b0;
      brk_q  <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
    end else if (!busy_q) begin
      if (wr_i || brk_i) begin
        busy_q <= 1'b1;
        brk_q  <= !wr_i;
        half_q <= 1'b0;
        bit_q  <= '0;
        sh_q   <= wr_i ? wr_data_i : '0;
      end
    end else if (tick_i) begin
      if (!half_q) begin
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
        if (bit_q == LAST_IDX) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          if (bit_q != '0) sh_q <= {1'b0, sh_q[DATA_W-1:1]};
        end
      end
    end
  end

  assign in_data = (bit_q != '0) && (bit_q != LAST_IDX);

  always_comb begin
    if (!busy_q)               tx_o = 1'b1;
    else if (bit_q == '0)      tx_o = 1'b0;
    else if (bit_q == LAST_IDX) tx_o = 1'b1;
    else                       tx_o = sh_q[0];
  end

  assign busy_o     = busy_q;
  assign data_bit_o = busy_q && !brk_q && in_data;
  assign last_bit_o = bit_q == MSB_IDX;
  assign half_o     = half_q;
  assign mid_tick_o = busy_q && tx_en_i && tick_i && !half_q;
  assign data_idx_o = bit_q - 1'b1;
endmodule

// File: rtl/uart_sync_clkgen.sv
module uart_sync_clkgen
  import uart_sync_pkg::*;
(
  input  ck_cfg_t cfg_i,
  input  logic    rx_en_i,
  input  logic    data_bit_i,
  input  logic    last_bit_i,
  input  logic    half_i,
  input  logic    mid_tick_i,
  output logic    ck_o,
  output logic    sample_o
);
  logic pulse_en, active_half;

  // phase 1 shifts the active half to the first half of the bit
  assign active_half = cfg_i.pha ? !half_i : half_i;
  assign pulse_en    = data_bit_i && (!last_bit_i || cfg_i.lbclk);
  assign ck_o        = cfg_i.pol ^ (pulse_en && active_half);
  // mid-bit is the capture edge in both phases
  assign sample_o    = rx_en_i && data_bit_i && mid_tick_i;
endmodule

// File: rtl/uart_sync_rx.sv
module uart_sync_rx #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] acc_q, acc_n, data_q;
  logic              valid_q;

  always_comb begin
    acc_n = acc_q;
    for (int i = 0; i < DATA_W; i++) begin
      if (idx_i == IDX_W'(i)) acc_n[i] = rx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (sample_i) begin
        acc_q <= acc_n;
        if (last_i) begin
          data_q  <= acc_n;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/uart_sync_master.sv
module uart_sync_master
  import uart_sync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              cfg_pol_i,
  input  logic              cfg_pha_i,
  input  logic              cfg_lbclk_i,
  input  logic              baud_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              brk_i,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              ck_o,
  output logic              busy_o,
  output logic              rx_sample_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int IDX_W = $clog2(DATA_W + 2);

  ck_cfg_t          ck_cfg;
  logic             data_bit, last_bit, half, mid_tick;
  logic [IDX_W-1:0] data_idx;

  uart_sync_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_en_i (tx_en_i),
    .rx_en_i (rx_en_i),
    .pol_i   (cfg_pol_i),
    .pha_i   (cfg_pha_i),
    .lbclk_i (cfg_lbclk_i),
    .cfg_o   (ck_cfg)
  );

  uart_sync_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .tick_i     (baud_tick_i),
    .wr_i       (wr_i),
    .wr_data_i  (wr_data_i),
    .brk_i      (brk_i),
    .busy_o     (busy_o),
    .tx_o       (tx_o),
    .data_bit_o (data_bit),
    .last_bit_o (last_bit),
    .half_o     (half),
    .mid_tick_o (mid_tick),
    .data_idx_o (data_idx)
  );

  uart_sync_clkgen u_clk (
    .cfg_i      (ck_cfg),
    .rx_en_i    (rx_en_i),
    .data_bit_i (data_bit),
    .last_bit_i (last_bit),
    .half_i     (half),
    .mid_tick_i (mid_tick),
    .ck_o       (ck_o),
    .sample_o   (rx_sample_o)
  );

  uart_sync_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (rx_sample_o),
    .last_i   (last_bit),
    .idx_i    (data_idx),
    .rx_i     (rx_i),
    .data_o   (rx_data_o),
    .valid_o  (rx_valid_o)
  );
endmodule

// File: rtl/uart_sync_master_chk.sv
module uart_sync_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic rx_en_i,
  input logic pol_i,
  input logic busy_o,
  input logic tx_o,
  input logic ck_o,
  input logic rx_sample_o,
  input logic rx_valid_o
);
  AST_IDLE_TX_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tx_o); // R2
  AST_CK_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ck_o == pol_i)); // R3
  AST_SAMPLE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sample_o |-> (busy_o && rx_en_i)); // R6
  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rx_sample_o)); // R7
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i || rx_en_i) |=> $stable(pol_i)); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !busy_o); // R11
endmodule

bind uart_sync_master uart_sync_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (tx_en_i),
  .rx_en_i     (rx_en_i),
  .pol_i       (ck_cfg.pol),
  .busy_o      (busy_o),
  .tx_o        (tx_o),
  .ck_o        (ck_o),
  .rx_sample_o (rx_sample_o),
  .rx_valid_o  (rx_valid_o)
);

// File: tb/uart_sync_master_tb.sv
module uart_sync_master_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, rx_en = 0, pol = 0, pha = 0, lb = 0;
  logic tick = 0, wr = 0, brk = 0, rx = 0;
  logic [DW-1:0] wdata = '0;
  logic tx, ck, busy, smp, vld;
  logic [DW-1:0] rdata;

  int checks = 0, fails = 0, cyc = 0, div = 3, tcnt = 0;
  int ck_edges = 0, samples = 0, valids = 0, busy_rises = 0;
  logic prev_ck = 0, prev_busy = 0, done = 0, cmp_on = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  uart_sync_master #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .cfg_pol_i(pol), .cfg_pha_i(pha), .cfg_lbclk_i(lb),
    .baud_tick_i(tick), .wr_i(wr), .wr_data_i(wdata), .brk_i(brk), .rx_i(rx),
    .tx_o(tx), .ck_o(ck), .busy_o(busy), .rx_sample_o(smp),
    .rx_data_o(rdata), .rx_valid_o(vld)
  );

  // reference model state
  logic m_busy, m_brk, m_half, m_pol, m_pha, m_lb, m_valid;
  int m_bit;
  logic [DW-1:0] m_byte, m_acc, m_rxd;

  function automatic logic m_sample();
    return rx_en && tx_en && m_busy && !m_brk && m_bit >= 1 && m_bit <= DW && tick && !m_half;
  endfunction

  function automatic logic m_tx();
    if (!m_busy) return 1'b1;
    if (m_bit == 0) return 1'b0;
    if (m_bit == DW + 1) return 1'b1;
    return m_brk ? 1'b0 : m_byte[m_bit-1];
  endfunction

  function automatic logic m_ck();
    logic on;
    on = m_busy && !m_brk && m_bit >= 1 && m_bit <= DW && (m_bit < DW || m_lb)
         && (m_pha ? !m_half : m_half);
    return m_pol ^ on;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_brk = 0; m_half = 0; m_bit = 0; m_byte = '0;
      m_pol = 0; m_pha = 0; m_lb = 0; m_valid = 0; m_acc = '0; m_rxd = '0;
    end else begin
      m_valid = 0;
      if (m_sample()) begin
        m_acc[m_bit-1] = rx;
        if (m_bit == DW) begin m_rxd = m_acc; m_valid = 1; end
      end
      if (!tx_en && !rx_en) begin m_pol = pol; m_pha = pha; m_lb = lb; end
      if (!tx_en) begin
        m_busy = 0; m_brk = 0; m_half = 0; m_bit = 0;
      end else if (!m_busy) begin
        if (wr || brk) begin
          m_busy = 1; m_brk = !wr; m_half = 0; m_bit = 0;
          m_byte = wr ? wdata : '0;
        end
      end else if (tick) begin
        if (!m_half) m_half = 1;
        else begin
          m_half = 0;
          if (m_bit == DW + 1) m_busy = 0; else m_bit++;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // stimulus-side tick and rx pattern
  always @(negedge clk) begin
    tcnt++;
    tick = (tcnt % div) == 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rx = lfsr[0];
  end

  // per-cycle comparison and port counters
  always @(negedge clk) begin
    #2;
    if (rst_n && cmp_on) begin
      chk(tx == m_tx(), "R2 tx", tx, m_tx());
      chk(busy == m_busy, "R2 busy", busy, m_busy);
      chk(ck == m_ck(), "R4 ck", ck, m_ck());
      chk(smp == m_sample(), "R6 sample", smp, m_sample());
      chk(vld == m_valid, "R7 valid", vld, m_valid);
      if (m_valid) chk(rdata == m_rxd, "R7 data", rdata, m_rxd);
    end
    if (rst_n) begin
      if (ck != prev_ck) ck_edges++;
      if (busy && !prev_busy) busy_rises++;
      if (smp) samples++;
      if (vld) valids++;
    end
    prev_ck = ck;
    prev_busy = busy;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] b);
    @(negedge clk); wr = 1; wdata = b;
    @(negedge clk); wr = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    cycles(2);
  endtask

  task automatic set_cfg(input logic p, input logic h, input logic l, input logic rxe);
    @(negedge clk); tx_en = 0; rx_en = 0; pol = p; pha = h; lb = l;
    @(negedge clk); tx_en = 1; rx_en = rxe;
    cycles(1);
  endtask

  task automatic clear_counts();
    ck_edges = 0; samples = 0; valids = 0; busy_rises = 0;
  endtask

  initial begin
    cycles(3);
    #3;
    // R1 reset state
    chk(tx === 1'b1, "R1 tx", tx, 1);
    chk(ck === 1'b0, "R1 ck", ck, 0);
    chk(busy === 1'b0 && smp === 1'b0 && vld === 1'b0, "R1 flags", {busy, smp, vld}, 0);
    @(negedge clk); rst_n = 1; cmp_on = 1;
    cycles(2);

    // R4 R5 R7: phase 0, last clock on
    set_cfg(0, 0, 1, 1);
    clear_counts();
    send(8'hA5);
    wait_idle();
    chk(ck_edges == 2 * DW, "R5 edges lb=1", ck_edges, 2 * DW);
    chk(samples == DW, "R6 samples", samples, DW);
    chk(valids == 1, "R7 valids", valids, 1);

    // R9 write while busy ignored
    clear_counts();
    send(8'h3C);
    cycles(5);
    send(8'hC3);
    wait_idle();
    cycles(4);
    chk(busy_rises == 1, "R9 busy write", busy_rises, 1);
    chk(busy == 0, "R9 idle", busy, 0);

    // R3 R5: polarity 1, phase 1, last clock off
    set_cfg(1, 1, 0, 1);
    chk(ck == 1'b1, "R3 idle high", ck, 1);
    clear_counts();
    send(8'h96);
    wait_idle();
    chk(ck_edges == 2 * (DW - 1), "R5 edges lb=0", ck_edges, 2 * (DW - 1));

    // R8 change while enabled ignored
    @(negedge clk); pol = 0; pha = 0; lb = 1;
    cycles(3);
    chk(ck == 1'b1, "R8 pol held", ck, 1);
    clear_counts();
    send(8'hFF);
    wait_idle();
    chk(ck_edges == 2 * (DW - 1), "R8 lb held", ck_edges, 2 * (DW - 1));

    // R6 receiver disabled: no strobes
    set_cfg(0, 1, 1, 0);
    clear_counts();
    send(8'h5A);
    wait_idle();
    chk(samples == 0, "R6 rx off", samples, 0);
    chk(ck_edges == 2 * DW, "R4 pha1 edges", ck_edges, 2 * DW);

    // R10 break, then priority
    @(negedge clk); rx_en = 1;
    clear_counts();
    @(negedge clk); brk = 1;
    @(negedge clk); brk = 0;
    wait_idle();
    chk(ck_edges == 0, "R10 brk edges", ck_edges, 0);
    chk(samples == 0, "R10 brk samples", samples, 0);
    clear_counts();
    @(negedge clk); brk = 1; wr = 1; wdata = 8'h81;
    @(negedge clk); brk = 0; wr = 0;
    wait_idle();
    chk(ck_edges == 2 * DW, "R10 wr wins", ck_edges, 2 * DW);

    // fastest tick rate
    div = 1;
    set_cfg(0, 0, 1, 1);
    clear_counts();
    send(8'h6B);
    wait_idle();
    chk(valids == 1 && ck_edges == 2 * DW, "R7 div1", ck_edges, 2 * DW);
    div = 4;

    // R11 abort mid frame
    send(8'hE7);
    cycles(17);
    @(negedge clk); tx_en = 0;
    @(negedge clk);
    #3;
    chk(busy == 0, "R11 busy", busy, 0);
    chk(tx == 1, "R11 tx", tx, 1);

    // R9 write while disabled
    clear_counts();
    send(8'h11);
    cycles(3);
    chk(busy_rises == 0, "R9 disabled", busy_rises, 0);
    @(negedge clk); tx_en = 1;
    cycles(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule